// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Status Flags

This block divides a 32-bit dividend by a 32-bit divisor, either as two's-complement numbers or as plain unsigned numbers, and reports the outcome the way a processor's status register expects it. A one-cycle start strobe launches an operation. The caller receives a quotient, a write-enable that says the quotient should be committed, and two sticky status flags: an overflow flag used by signed division and a carry flag used by unsigned division. The block also has a one-cycle completion strobe and a request line for a range exception.

A nonzero divisor runs a restoring shift-subtract loop, one quotient bit per clock. Signed operands are first turned into magnitudes, and the quotient sign is restored at the end, so the result truncates toward zero. A zero divisor is detected when the operation is accepted. The loop is skipped. The flag for the current mode is set, no quotient is written, and if the exception enable is high a range exception is requested together with the completion strobe.

The controller has two states. IDLE accepts a start. Its transitions are IDLE→IDLE when the divisor is zero (completion on the next cycle) and IDLE→RUN when the divisor is nonzero. RUN performs one step per cycle. Its transitions are RUN→RUN while steps remain and RUN→IDLE on the last step. A start seen in RUN is ignored.

Top module: `int_divider`

## Requirements
- R1: Signed mode (`is_signed`=1) with a nonzero divisor: `quotient` is the two's-complement quotient truncated toward zero, `wr_en` is 1 with `done`, and `ov_flag` is cleared to 0.
- R2: Signed mode with a zero divisor: `ov_flag` becomes 1, `wr_en` stays 0, and `quotient` keeps its previous value.
- R3: Unsigned mode (`is_signed`=0) with a nonzero divisor: `quotient` is the unsigned quotient, `wr_en` is 1 with `done`, and `cy_flag` is cleared to 0.
- R4: Unsigned mode with a zero divisor: `cy_flag` becomes 1, `wr_en` stays 0, and `quotient` keeps its previous value.
- R5: `range_exc` pulses together with `done` exactly when the divisor was zero and `exc_en` was 1 at start, in either mode. It is never raised for a nonzero divisor.
- R6: Signed operations never change `cy_flag`, and unsigned operations never change `ov_flag`. Neither flag changes except in a cycle where `done` is 1.
- R7: Counting the clock edge that accepts `start` as edge 1, `done` is visible after edge 1 for a zero divisor and after edge W+1 (33 for the default) for a nonzero divisor.
- R8: Signed division of the most negative value (0x80000000) by -1 returns 0x80000000 with `wr_en` 1 and `ov_flag` 0.
- R9: `done` lasts exactly one cycle, and `quotient` changes only in a cycle where `done` is 1.
- R10: A `start` asserted while an operation is running has no effect on that operation's result, its flags, or the number of completions.
- R11: After reset, `quotient`, `wr_en`, `ov_flag`, `cy_flag`, `done` and `range_exc` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, accepted only in IDLE |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned division |
| dividend | input | 32 | Numerator, sampled at start |
| divisor | input | 32 | Denominator, sampled at start |
| exc_en | input | 1 | Range-exception enable, sampled at start |
| quotient | output | 32 | Last written quotient, held between completions |
| wr_en | output | 1 | Quotient should be committed; only with `done` |
| ov_flag | output | 1 | Overflow status flag (signed mode) |
| cy_flag | output | 1 | Carry status flag (unsigned mode) |
| done | output | 1 | One-cycle completion strobe |
| range_exc | output | 1 | Range-exception request, with `done` |

## Verification
A zero-divisor result is due one edge after the accepting edge, and a nonzero-divisor result is due W+1 edges after it. The bench drives `start` on a falling edge, counts falling edges until `done` appears, and compares that count with the expected latency before it reads the quotient and flags in the same half-cycle. One falling edge later it checks that `done` has dropped and that the quotient has held. It also checks the flag belonging to the other mode against its running model.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
    import intdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic divisor_zero,
    output logic accept_zero,
    output logic accept_run,
    output logic step,
    output logic last
);
    localparam int CNT_W = $clog2(W + 1);

    div_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start && !divisor_zero) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cnt_q == CNT_W'(W - 1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_zero = 1'b0;
        accept_run  = 1'b0;
        step        = 1'b0;
        last        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_zero = start && divisor_zero;
                accept_run  = start && !divisor_zero;
            end
            ST_RUN: begin
                step = 1'b1;
                last = (cnt_q == CNT_W'(W - 1));
            end
            default: ;
        endcase
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= CNT_W'(W - 1)));

    assert_last_exits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (state_q == ST_IDLE));

    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> (state_q == ST_RUN));

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] num_mag,
    input  logic [W-1:0] den_mag,
    output logic [W-1:0] quo_next
);
    logic [W-1:0] rem_q, quo_q, den_q;
    logic [W:0]   shifted;
    logic         fits;
    logic [W-1:0] rem_next;

    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        fits     = (shifted >= {1'b0, den_q});
        rem_next = fits ? W'(shifted - {1'b0, den_q}) : shifted[W-1:0];
        quo_next = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= num_mag;
            den_q <= den_mag;
        end else if (step) begin
            rem_q <= rem_next;
            quo_q <= quo_next;
        end
    end

    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (den_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         exc_en,
    output logic [W-1:0] quotient,
    output logic         wr_en,
    output logic         ov_flag,
    output logic         cy_flag,
    output logic         done,
    output logic         range_exc
);
    logic         divisor_zero;
    logic         accept_zero, accept_run, step, last;
    logic         neg_a, neg_b;
    logic [W-1:0] mag_a, mag_b, quo_next, quo_signed;
    logic         neg_q_r, mode_r;

    always_comb begin
        divisor_zero = (divisor == '0);
        neg_a        = is_signed && dividend[W-1];
        neg_b        = is_signed && divisor[W-1];
        mag_a        = neg_a ? (-dividend) : dividend;
        mag_b        = neg_b ? (-divisor)  : divisor;
        quo_signed   = neg_q_r ? (-quo_next) : quo_next;
    end

    div_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .divisor_zero (divisor_zero),
        .accept_zero  (accept_zero),
        .accept_run   (accept_run),
        .step         (step),
        .last         (last)
    );

    div_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_run),
        .step     (step),
        .num_mag  (mag_a),
        .den_mag  (mag_b),
        .quo_next (quo_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient  <= '0;
            wr_en     <= 1'b0;
            ov_flag   <= 1'b0;
            cy_flag   <= 1'b0;
            done      <= 1'b0;
            range_exc <= 1'b0;
            neg_q_r   <= 1'b0;
            mode_r    <= 1'b0;
        end else begin
            done      <= 1'b0;
            wr_en     <= 1'b0;
            range_exc <= 1'b0;
            if (accept_run) begin
                neg_q_r <= neg_a ^ neg_b;
                mode_r  <= is_signed;
            end
            if (accept_zero) begin
                mode_r    <= is_signed;
                done      <= 1'b1;
                range_exc <= exc_en;
                if (is_signed) ov_flag <= 1'b1;
                else           cy_flag <= 1'b1;
            end
            if (last) begin
                done     <= 1'b1;
                wr_en    <= 1'b1;
                quotient <= quo_signed;
                if (mode_r) ov_flag <= 1'b0;
                else        cy_flag <= 1'b0;
            end
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_quotient_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (quotient == $past(quotient)));

    assert_write_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

    assert_zero_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_zero |=> (done && !wr_en));

    assert_exc_only_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |-> (done && !wr_en));

    assert_carry_kept_signed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_r) |-> (cy_flag == $past(cy_flag)));

    assert_ovf_kept_unsigned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_r) |-> (ov_flag == $past(ov_flag)));

    assert_flags_move_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ov_flag) && $stable(cy_flag)));

endmodule

// File: tb/int_divider_bench.sv
`timescale 1ns/1ps
module int_divider_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         exc_en = 1'b0;
    logic [W-1:0] quotient;
    logic         wr_en, ov_flag, cy_flag, done, range_exc;

    int checks = 0;
    int failures = 0;
    logic         ov_m = 1'b0;
    logic         cy_m = 1'b0;
    logic [W-1:0] q_m = '0;

    always #2.5 clk = ~clk;

    int_divider #(.W(W)) u_int_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .exc_en(exc_en),
        .quotient(quotient), .wr_en(wr_en), .ov_flag(ov_flag),
        .cy_flag(cy_flag), .done(done), .range_exc(range_exc)
    );

    function automatic logic [W-1:0] exp_quot(input logic sg, input logic [W-1:0] a,
                                              input logic [W-1:0] b);
        if (!sg) return a / b;
        if (a == {1'b1, {(W-1){1'b0}}} && b == '1) return a;
        return W'($signed(a) / $signed(b));
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one operation; poke = issue a second start while busy (R10)
    task automatic run_op(input logic sg, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic ee, input logic poke);
        int lat;
        logic zero;
        logic [W-1:0] q_old;
        zero = (b == '0);
        @(negedge clk);
        is_signed = sg; dividend = a; divisor = b; exc_en = ee; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (poke && lat == 3) begin
                is_signed = ~sg; divisor = '0; exc_en = 1'b1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R7", "latency", 64'(lat), zero ? 64'd1 : 64'(W + 1));
        q_old = q_m;
        if (zero) begin
            if (sg) ov_m = 1'b1; else cy_m = 1'b1;
            chk(sg ? "R2" : "R4", "wr_en zero div", 64'(wr_en), 64'd0);
            chk(sg ? "R2" : "R4", "quotient kept", 64'(quotient), 64'(q_old));
        end else begin
            q_m = exp_quot(sg, a, b);
            if (sg) ov_m = 1'b0; else cy_m = 1'b0;
            chk(sg ? "R1" : "R3", "wr_en", 64'(wr_en), 64'd1);
            chk(sg ? "R1" : "R3", "quotient", 64'(quotient), 64'(q_m));
        end
        chk("R5", "range_exc", 64'(range_exc), 64'(zero && ee));
        chk("R6", "ov_flag", 64'(ov_flag), 64'(ov_m));
        chk("R6", "cy_flag", 64'(cy_flag), 64'(cy_m));
        @(negedge clk);
        chk("R9", "done pulse", 64'(done), 64'd0);
        chk("R9", "quotient hold", 64'(quotient), 64'(q_m));
        if (poke) begin
            repeat (3) @(negedge clk);
            chk("R10", "no extra done", 64'(done), 64'd0);
            chk("R10", "flags after poke", 64'({ov_flag, cy_flag}), 64'({ov_m, cy_m}));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] a, b;
        logic sg, ee;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "outputs in reset", 64'({quotient, wr_en, ov_flag, cy_flag, done, range_exc}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "outputs after reset", 64'({quotient, wr_en, ov_flag, cy_flag, done, range_exc}), 64'd0);

        // directed corners
        run_op(1'b1, 32'd100, 32'd7, 1'b0, 1'b0);          // R1
        run_op(1'b1, -32'sd100, 32'd7, 1'b0, 1'b0);        // R1 truncation toward zero
        run_op(1'b1, 32'd100, -32'sd7, 1'b0, 1'b0);        // R1
        run_op(1'b1, 32'd5, 32'd0, 1'b1, 1'b0);            // R2, R5
        run_op(1'b0, 32'hFFFF_FFFF, 32'd3, 1'b1, 1'b0);    // R3, R5 none
        run_op(1'b0, 32'd9, 32'd0, 1'b0, 1'b0);            // R4, R5 off
        run_op(1'b0, 32'd9, 32'd0, 1'b1, 1'b0);            // R4, R5 on
        run_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0); // R8
        chk("R8", "min over -1", 64'(quotient), 64'h8000_0000);
        run_op(1'b1, 32'd0, 32'd0, 1'b0, 1'b0);            // R2 with exc off
        run_op(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0); // R3
        run_op(1'b1, 32'd77, 32'd1, 1'b0, 1'b1);           // R10
        run_op(1'b0, 32'd1000, 32'd10, 1'b0, 1'b1);        // R10

        // constrained random
        for (int i = 0; i < 300; i++) begin
            sg = 1'($urandom);
            ee = 1'($urandom);
            a  = $urandom;
            case ($urandom % 8)
                0: b = '0;
                1: b = 32'($urandom % 16);
                2: b = '1;
                3: begin b = 32'h8000_0000; end
                default: b = $urandom >> ($urandom % 32);
            endcase
            if ($urandom % 16 == 0) a = 32'h8000_0000;
            run_op(sg, a, b, ee, 1'($urandom % 20 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule